// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is the target side of a two-wire serial bus with an open-drain data line. It gives the bus a byte-wide memory behind a 13-bit address latch. A bus controller writes by sending the device byte with its direction bit clear, then two address bytes, then any number of data bytes. It reads by sending the device byte with its direction bit set. It then clocks out bytes for as long as it acknowledges them.

The address latch keeps its value between transactions. A read header with no address bytes therefore continues where the last access stopped. A random read is a write header that sets the address, followed by a repeated start and a read header. The clock and data lines are synchronised to the system clock. The block pulls the data line low through an output-enable pin and never drives it high.

The storage is a register array of `2**MEM_AW` bytes, 1024 with the default parameters. It is indexed by the low `MEM_AW` bits of the 13-bit latch, so higher addresses alias onto it. There is no stream interface at the block edge, so no valid/ready back-pressure applies. Both bus lines are plain level pins.

Top module: `twowire_mem_slave`

## Requirements
- R1: After reset `sda_oe` is 0. A device byte whose upper seven bits equal `DEV_ID` (default 7'h50) is acknowledged: `sda_oe`=1 during the ninth clock. A device byte with any other value gets no acknowledge, and every byte after it is ignored until the next start.
- R2: Bit 0 of the device byte selects the direction: 1 is a read and 0 is a write.
- R3: On a write, the first byte after the device byte sets latch bits 12..8 from its bits 4..0, and its bits 7..5 are ignored. The second byte sets latch bits 7..0. Both bytes are acknowledged.
- R4: Each later write data byte is acknowledged and stored at the latch address, and the latch then increments.
- R5: A read with no preceding address bytes starts at the latch value, which is one past the last byte accessed. This holds across separate transactions.
- R6: The latch increments after each byte read or written, and it wraps from 13'h1FFF to 13'h0000.
- R7: A controller acknowledge (data line low) in the ninth clock of a read byte makes the block send the next sequential byte. A no-acknowledge makes it release the data line and return to idle.
- R8: A stop or a start issued during the ninth clock of a read byte ends the read, with the data line released.
- R9: A random read is a write header of device byte, high address and low address, then a repeated start and a read header. It returns data from the newly latched address.
- R10: A start or stop seen in the middle of a byte abandons that byte. A partly received data byte is not written and the latch does not increment.
- R11: Read data goes out most significant bit first, and `sda_oe` changes only while the clock line is low.
- R12: The array holds `2**MEM_AW` bytes at latch bits `MEM_AW-1..0`, so with the default 1024 bytes, latch 13'h03FE and 13'h1FFE name the same byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level, as seen on the wired line |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
The hardest state to reach is the end of a read byte, where four different endings must each leave the line released. These are a no-acknowledge followed by a stop, a no-acknowledge followed by a start, a stop inside the ninth clock, and a start inside the ninth clock. The bench drives a wired-AND bus model and runs sequential reads that close with each ending in turn. It then opens a new read with no address bytes and checks that the latch continued correctly. A byte abandoned mid-transfer is reached by stopping after four data bits and then reading the untouched location back.

// File: rtl/twm_pkg.sv
package twm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_AHI,
    ST_ALO,
    ST_WDAT,
    ST_RDAT
  } twm_state_e;
endpackage

// File: rtl/twm_line_sync.sv
module twm_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_hi,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_p, sda_p;
  logic scl_prev, sda_prev;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_p <= 1'b1;
          sda_p <= 1'b1;
        end else begin
          scl_p <= scl_i;
          sda_p <= sda_i;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_p <= '1;
          sda_p <= '1;
        end else begin
          scl_p <= {scl_p[STAGES-2:0], scl_i};
          sda_p <= {sda_p[STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_prev <= scl_p[STAGES-1];
      sda_prev <= sda_p[STAGES-1];
    end
  end

  assign scl_hi    = scl_p[STAGES-1];
  assign sda_lvl   = sda_p[STAGES-1];
  assign scl_rise  = scl_hi & ~scl_prev;
  assign scl_fall  = ~scl_hi & scl_prev;
  assign start_det = scl_hi & scl_prev & sda_prev & ~sda_lvl;
  assign stop_det  = scl_hi & scl_prev & ~sda_prev & sda_lvl;
endmodule

// File: rtl/twm_mem_array.sv
module twm_mem_array #(
  parameter int LATCH_W = 13,
  parameter int MEM_AW  = 10,
  parameter int DW      = 8
) (
  input  logic               clk,
  input  logic               we,
  input  logic [LATCH_W-1:0] addr,
  input  logic [DW-1:0]      wdata,
  output logic [DW-1:0]      rdata
);
  localparam int DEPTH = 1 << MEM_AW;
  logic [DW-1:0] mem_q [DEPTH];
  logic [MEM_AW-1:0] idx;

  assign idx = addr[MEM_AW-1:0];

  generate
    if (LATCH_W > MEM_AW) begin : g_alias
      logic unused_hi_bits;
      assign unused_hi_bits = ^addr[LATCH_W-1:MEM_AW];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (we) mem_q[idx] <= wdata;
  end

  assign rdata = mem_q[idx];
endmodule

// File: rtl/twm_ctrl.sv
module twm_ctrl
  import twm_pkg::*;
#(
  parameter logic [6:0] DEV_ID  = 7'h50,
  parameter int         LATCH_W = 13
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_hi,
  input  logic               sda_in,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               start_det,
  input  logic               stop_det,
  input  logic [7:0]         mem_rdata,
  output logic [LATCH_W-1:0] addr_q,
  output logic               mem_we,
  output logic [7:0]         mem_wdata,
  output logic               sda_oe
);
  localparam int HI_W = LATCH_W - 8;

  twm_state_e st_q;
  logic [3:0] cnt_q;
  logic [7:0] rx_q, tx_q;
  logic       oe_q, mack_q;
  logic       quiet, byte_end, ack_end, ahi_done, alo_done, load_rd, addr_inc;

  assign quiet    = !start_det && !stop_det;
  assign byte_end = quiet && scl_fall && (cnt_q == 4'd8);
  assign ack_end  = quiet && scl_fall && (cnt_q == 4'd9);
  assign ahi_done = byte_end && (st_q == ST_AHI);
  assign alo_done = byte_end && (st_q == ST_ALO);
  assign mem_we   = byte_end && (st_q == ST_WDAT);
  assign load_rd  = ack_end && (((st_q == ST_DEV) && rx_q[0]) ||
                                ((st_q == ST_RDAT) && mack_q));
  assign addr_inc  = mem_we || load_rd;
  assign mem_wdata = rx_q;
  assign sda_oe    = oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else if (ahi_done) addr_q[LATCH_W-1:8] <= rx_q[HI_W-1:0];
    else if (alo_done) addr_q[7:0] <= rx_q;
    else if (addr_inc) addr_q <= addr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      rx_q   <= '0;
      tx_q   <= '0;
      oe_q   <= 1'b0;
      mack_q <= 1'b0;
    end else if (start_det) begin
      st_q  <= ST_DEV;
      cnt_q <= '0;
      oe_q  <= 1'b0;
    end else if (stop_det) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      oe_q  <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: ;
        ST_RDAT: begin
          if (scl_rise) begin
            if (cnt_q < 4'd8) cnt_q <= cnt_q + 4'd1;
            else if (cnt_q == 4'd8) begin
              mack_q <= ~sda_in;
              cnt_q  <= 4'd9;
            end
          end
          if (scl_fall) begin
            if (cnt_q >= 4'd1 && cnt_q <= 4'd7) begin
              tx_q <= {tx_q[6:0], 1'b0};
              oe_q <= ~tx_q[6];
            end else if (cnt_q == 4'd8) begin
              oe_q <= 1'b0;
            end else if (cnt_q == 4'd9) begin
              cnt_q <= '0;
              if (mack_q) begin
                tx_q <= mem_rdata;
                oe_q <= ~mem_rdata[7];
              end else begin
                st_q <= ST_IDLE;
                oe_q <= 1'b0;
              end
            end
          end
        end
        default: begin
          if (scl_rise && cnt_q < 4'd8) begin
            rx_q  <= {rx_q[6:0], sda_in};
            cnt_q <= cnt_q + 4'd1;
          end
          if (byte_end) begin
            if (st_q == ST_DEV && rx_q[7:1] != DEV_ID) begin
              st_q  <= ST_IDLE;
              cnt_q <= '0;
            end else begin
              oe_q  <= 1'b1;
              cnt_q <= 4'd9;
            end
          end
          if (ack_end) begin
            oe_q  <= 1'b0;
            cnt_q <= '0;
            unique case (st_q)
              ST_DEV: begin
                if (rx_q[0]) begin
                  st_q <= ST_RDAT;
                  tx_q <= mem_rdata;
                  oe_q <= ~mem_rdata[7];
                end else begin
                  st_q <= ST_AHI;
                end
              end
              ST_AHI:  st_q <= ST_ALO;
              default: st_q <= ST_WDAT;
            endcase
          end
        end
      endcase
    end
  end

  assert_oe_moves_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_q != $past(oe_q)) |-> !scl_hi);
  assert_idle_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE) |-> !oe_q);
  assert_start_rearms_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (st_q == ST_DEV && cnt_q == 4'd0));
  assert_stop_releases_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (st_q == ST_IDLE && !oe_q));
  assert_latch_wraps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_inc && addr_q == '1) |=> (addr_q == '0));
  assert_foreign_id_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_end && st_q == ST_DEV && rx_q[7:1] != DEV_ID) |=> (st_q == ST_IDLE && !oe_q));
endmodule

// File: rtl/twowire_mem_slave.sv
module twowire_mem_slave #(
  parameter logic [6:0] DEV_ID      = 7'h50,
  parameter int         LATCH_W     = 13,
  parameter int         MEM_AW      = 10,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  logic scl_hi, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic mem_we;
  logic [7:0] mem_wdata, mem_rdata;
  logic [LATCH_W-1:0] addr;

  twm_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_hi(scl_hi), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
  );

  twm_ctrl #(.DEV_ID(DEV_ID), .LATCH_W(LATCH_W)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .scl_hi(scl_hi), .sda_in(sda_lvl),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
    .stop_det(stop_det), .mem_rdata(mem_rdata), .addr_q(addr),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .sda_oe(sda_oe)
  );

  twm_mem_array #(.LATCH_W(LATCH_W), .MEM_AW(MEM_AW), .DW(8)) i_mem (
    .clk(clk), .we(mem_we), .addr(addr), .wdata(mem_wdata), .rdata(mem_rdata)
  );
endmodule

// File: tb/test_twowire_mem_slave.sv
module test_twowire_mem_slave;
  localparam int DEPTH = 1024;
  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, m_sda = 1'b1;
  logic sda_oe, sda_line;
  int checks = 0, fails = 0, moves_high = 0;
  logic [7:0] mm [int];
  int maddr = 0;
  logic prev_oe = 1'b0;
  bit done = 0;

  always #4 clk = ~clk;
  assign sda_line = m_sda & ~sda_oe;

  twowire_mem_slave i_twowire_mem_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe)
  );

  // R11: every clock, the bench checks that the data driver holds still while the clock line is high
  always @(posedge clk) begin
    if (rst_n && sda_oe !== prev_oe && scl) moves_high++;
    prev_oe <= sda_oe;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic q(); repeat (8) @(negedge clk); endtask

  task automatic bus_start();
    scl = 0; q(); m_sda = 1; q(); scl = 1; q(); m_sda = 0; q(); scl = 0; q();
  endtask

  task automatic bus_stop();
    scl = 0; q(); m_sda = 0; q(); scl = 1; q(); m_sda = 1; q();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; q(); scl = 1; q(); scl = 0; q();
    end
    m_sda = 1; q(); scl = 1; q(); ack = ~sda_line; scl = 0; q();
  endtask

  task automatic recv_bits(output logic [7:0] d);
    m_sda = 1;
    for (int i = 7; i >= 0; i--) begin
      q(); scl = 1; q(); d[i] = sda_line; scl = 0;
    end
  endtask

  task automatic check_byte(input logic [7:0] d, input string tag);
    logic [7:0] e;
    e = mm[maddr % DEPTH];
    chk(d === e, tag, d, e);
    maddr = (maddr + 1) & 'h1FFF;
  endtask

  task automatic check_released(input string tag);
    q(); chk(sda_oe == 1'b0, tag, sda_oe, 0);
  endtask

  // term: 0 no-ack then stop, 1 no-ack then start, 2 stop in ninth, 3 start in ninth
  task automatic rd_run(input bit do_start, input int n, input int term, input string tag);
    bit ack;
    logic [7:0] d;
    if (do_start) bus_start();
    send_byte(8'hA1, ack);
    chk(ack, "R2 read header acknowledged", ack, 1);
    for (int i = 0; i < n; i++) begin
      recv_bits(d);
      if (i < n - 1) begin
        m_sda = 0; q(); scl = 1; q(); scl = 0; q(); m_sda = 1;
      end else if (term == 0 || term == 1) begin
        m_sda = 1; q(); scl = 1; q(); scl = 0; q();
      end else if (term == 2) begin
        m_sda = 0; q(); scl = 1; q(); m_sda = 1; q();
      end else begin
        m_sda = 1; q(); scl = 1; q(); m_sda = 0; q(); scl = 0; q();
      end
      check_byte(d, tag);
    end
    if (term == 0) begin bus_stop(); check_released("R7 released after no-ack and stop"); end
    if (term == 1) begin check_released("R7 released after no-ack"); bus_start(); end
    if (term == 2) check_released("R8 released after stop in ninth clock");
    if (term == 3) check_released("R8 released after start in ninth clock");
  endtask

  task automatic header(input logic [7:0] ahi, input logic [7:0] alo);
    bit ack;
    bus_start();
    send_byte(8'hA0, ack); chk(ack, "R1 matching device byte acknowledged", ack, 1);
    send_byte(ahi, ack);   chk(ack, "R3 high address acknowledged", ack, 1);
    send_byte(alo, ack);   chk(ack, "R3 low address acknowledged", ack, 1);
    maddr = {ahi[4:0], alo};
  endtask

  task automatic wr_run(input logic [7:0] ahi, input logic [7:0] alo, input int n, input logic [7:0] base);
    bit ack;
    header(ahi, alo);
    for (int i = 0; i < n; i++) begin
      send_byte(base + 8'(i * 17), ack);
      chk(ack, "R4 data byte acknowledged", ack, 1);
      mm[maddr % DEPTH] = base + 8'(i * 17);
      maddr = (maddr + 1) & 'h1FFF;
    end
    bus_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    bit ack;
    repeat (5) @(negedge clk);
    chk(sda_oe == 1'b0, "R1 reset releases line", sda_oe, 0);
    rst_n = 1;
    q();
    // R3: bits 7..5 of the high byte (0xE1) are ignored, so the latch is 0x0123
    wr_run(8'hE1, 8'h23, 12, 8'h11);
    // R9, R11: random read of three bytes, MSB-first data compared with the model
    header(8'h01, 8'h23);
    rd_run(1, 3, 0, "R9 random read data");
    // R5: current-address reads continue across transactions, covering each ending
    rd_run(1, 2, 1, "R5 current-address read");
    rd_run(0, 1, 2, "R7 continue after no-ack and start");
    rd_run(1, 1, 3, "R5 continue after stop in ninth");
    rd_run(0, 1, 0, "R8 continue after start in ninth");
    // R1: a foreign device byte and the byte after it get no acknowledge
    bus_start();
    send_byte(8'hA2, ack); chk(!ack, "R1 foreign device byte not acknowledged", ack, 0);
    send_byte(8'h00, ack); chk(!ack, "R1 bytes after foreign id ignored", ack, 0);
    bus_stop();
    rd_run(1, 1, 0, "R1 latch untouched by foreign access");
    // R6: a write and a read across the 1FFF to 0000 wrap
    wr_run(8'h1F, 8'hFE, 3, 8'hA1);
    chk(maddr == 1, "R6 model latch after wrap", maddr, 1);
    header(8'h1F, 8'hFE);
    rd_run(1, 3, 0, "R6 read across wrap");
    rd_run(1, 1, 0, "R6 latch continues after wrap");
    // R12: 0x03FE aliases 0x1FFE
    header(8'h03, 8'hFE);
    rd_run(1, 1, 0, "R12 aliased location");
    // R10: abandon a data byte after four bits; no write, no increment
    header(8'h01, 8'h25);
    for (int i = 0; i < 4; i++) begin
      m_sda = 1'b0; q(); scl = 1; q(); scl = 0; q();
    end
    bus_stop();
    rd_run(1, 1, 0, "R10 partial byte discarded");
    chk(moves_high == 0, "R11 data driver still while clock high", moves_high, 0);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule